// File: doc/BRIEF.md
# Bus Cycle Timeout Watchdog

This block sits beside a processor bus whose cycles end on an asynchronous handshake. The processor asserts an active-low address strobe to open a cycle, and a device closes it by pulling an active-low data-acknowledge line. When nothing answers, the processor stalls forever. The watchdog counts clock edges while a cycle is open and unanswered. If the count reaches a selected power of two first, it ends the cycle itself.

A mode input chooses how the cycle is ended. In one mode the block fakes the acknowledge, so the stuck cycle simply completes. In the other mode it raises bus error, so the processor can trap the access. The timeout is not a loaded compare value. It is the weight of one binary counter bit, picked by a 3-bit select.

The select is arranged so that a tied-off (zero) select gives the longest interval, 16384 clocks. Short intervals, down to 128 clocks, are therefore used only when a designer chooses them on purpose. Both bus inputs are resynchronised with two flops before use. The block drives nothing else on the bus.

Top module: `bus_cycle_watchdog`

## Requirements
- R1: After reset, both `fake_ack` and `bus_err` are low.
- R2: While the address strobe is negated (high), the counter is held at zero and neither output is asserted, however long the idle time lasts.
- R3: With `mode_berr` = 1, an unanswered cycle raises `bus_err` and leaves `fake_ack` low. The rising edge appears at the (3 + 2^(14 − `tap_sel`))-th rising clock edge, counting the first edge that samples `as_n` low as edge 1.
- R4: With `mode_berr` = 0, the same timeout raises `fake_ack` at the same edge and leaves `bus_err` low. The two outputs are never high together.
- R5: `tap_sel` picks counter bit (14 − `tap_sel`) as the timeout. The value 0 gives 16384 clocks and the value 7 gives 128 clocks, and each increment of `tap_sel` halves the interval.
- R6: If `ack_n` is seen low before the timeout, counting stops and neither output is asserted for the rest of that cycle, even if the strobe stays low for longer than the timeout.
- R7: Once asserted, the termination output stays high until the strobe is negated. It then falls at the third rising edge that samples `as_n` high.
- R8: Each new cycle starts counting from zero, so a cycle that follows a timed-out or acknowledged cycle gets the full timeout again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| as_n | input | 1 | Address strobe from the processor, active low, asynchronous |
| ack_n | input | 1 | Data-acknowledge from bus devices, active low, asynchronous |
| tap_sel | input | 3 | Timeout select: counter bit 14 − tap_sel |
| mode_berr | input | 1 | 1: end stuck cycles with bus error; 0: end them with a forced acknowledge |
| fake_ack | output | 1 | Forced data-acknowledge request, active high |
| bus_err | output | 1 | Bus error request, active high |

## Verification
A counter that is not cleared between cycles shows up in the next cycle as a termination that comes early by the leftover count. An acknowledge flag that is lost shows up as a spurious termination one timeout after a device has answered. Both errors appear at the ports within one timeout interval. They are caught by a reference model that is compared on every clock, and by exact edge counts for the assert and release latencies.

// File: rtl/bus_cycle_watchdog.sv
module bus_cycle_watchdog #(
  parameter int TAP_LO    = 7,
  parameter int TAP_SEL_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 as_n,
  input  logic                 ack_n,
  input  logic [TAP_SEL_W-1:0] tap_sel,
  input  logic                 mode_berr,
  output logic                 fake_ack,
  output logic                 bus_err
);
  localparam int CNT_W  = TAP_LO + (1 << TAP_SEL_W);
  localparam int TAP_HI = CNT_W - 1;
  localparam int TIDX_W = $clog2(CNT_W);

  logic [1:0]        as_sync, ack_sync;
  logic              as_s, ack_s;
  logic [CNT_W-1:0]  cnt;
  logic              acked, fired;
  logic [TIDX_W-1:0] tap_idx;
  logic              tap_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      as_sync  <= '0;
      ack_sync <= '0;
    end else begin
      as_sync  <= {as_sync[0], ~as_n};
      ack_sync <= {ack_sync[0], ~ack_n};
    end

  assign as_s    = as_sync[1];
  assign ack_s   = ack_sync[1];
  assign tap_idx = TIDX_W'(TAP_HI) - TIDX_W'(tap_sel);
  assign tap_hit = cnt[tap_idx];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt   <= '0;
      acked <= 1'b0;
      fired <= 1'b0;
    end else if (!as_s) begin
      cnt   <= '0;
      acked <= 1'b0;
      fired <= 1'b0;
    end else if (!fired && !acked) begin
      if (ack_s)        acked <= 1'b1;
      else if (tap_hit) fired <= 1'b1;
      else              cnt   <= cnt + 1'b1;
    end

  assign fake_ack = fired & ~mode_berr;
  assign bus_err  = fired &  mode_berr;

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !as_s |=> (cnt == '0) && !fake_ack && !bus_err);  // R2
  AST_ONE_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fake_ack, bus_err}));  // R4
  AST_FIRE_AT_TAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fired) |-> ($past(cnt) == (CNT_W'(1) << $past(tap_idx))));  // R5
  AST_ACK_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    (acked && as_s) |=> !fired);  // R6
  AST_HOLD_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    (fired && as_s) |=> fired);  // R7
  AST_FRESH_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(as_s) |-> (cnt == '0));  // R8
endmodule

// File: tb/test_bus_cycle_watchdog.sv
module test_bus_cycle_watchdog;
  logic clk = 0, rst_n = 0, as_n = 1, ack_n = 1, mode_berr = 1;
  logic [2:0] tap_sel = 3'd7;
  logic fake_ack, bus_err;
  int vectors = 0, errors = 0;

  always #10 clk = ~clk;

  bus_cycle_watchdog i_bus_cycle_watchdog (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .ack_n(ack_n),
    .tap_sel(tap_sel), .mode_berr(mode_berr),
    .fake_ack(fake_ack), .bus_err(bus_err));

  // behavioural reference
  bit m_s1, m_s2, m_a1, m_a2, m_acked, m_fired;
  int m_cnt;
  always @(posedge clk) begin
    if (!rst_n) begin
      {m_s1, m_s2, m_a1, m_a2, m_acked, m_fired} = '0;
      m_cnt = 0;
    end else begin
      if (!m_s2) begin
        m_cnt = 0; m_acked = 0; m_fired = 0;
      end else if (!m_fired && !m_acked) begin
        if (m_a2) m_acked = 1;
        else if (m_cnt >= (1 << (14 - int'(tap_sel)))) m_fired = 1;
        else m_cnt++;
      end
      m_s2 = m_s1; m_s1 = !as_n;
      m_a2 = m_a1; m_a1 = !ack_n;
    end
  end

  always @(negedge clk) begin
    vectors++;
    if (fake_ack !== (m_fired && !mode_berr) || bus_err !== (m_fired && mode_berr)) begin
      errors++;
      $display("FAIL R3/R4 model: fake_ack=%b bus_err=%b expected %b %b at %0t",
               fake_ack, bus_err, m_fired && !mode_berr, m_fired && mode_berr, $time);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic timeout_cycle(input int sel, input bit berr, input string req);
    int n = 0;
    int exp = 3 + (1 << (14 - sel));
    @(negedge clk);
    tap_sel = 3'(sel); mode_berr = berr; as_n = 0;
    do begin
      @(posedge clk); @(negedge clk); n++;
    end while (!(fake_ack || bus_err) && n < 20000);
    check(n == exp, req, n, exp);
    check(berr ? (bus_err && !fake_ack) : (fake_ack && !bus_err),
          berr ? "R3 kind" : "R4 kind", {fake_ack, bus_err}, berr ? 1 : 2);
    repeat (25) @(negedge clk);
    check(fake_ack || bus_err, "R7 hold", 0, 1);
    as_n = 1; n = 0;
    do begin
      @(posedge clk); @(negedge clk); n++;
    end while ((fake_ack || bus_err) && n < 50);
    check(n == 3, "R7 release", n, 3);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!fake_ack && !bus_err, "R1 reset", {fake_ack, bus_err}, 0);
    rst_n = 1;
    repeat (400) @(negedge clk);
    check(!fake_ack && !bus_err, "R2 idle", {fake_ack, bus_err}, 0);

    timeout_cycle(7, 1, "R3 latency tap7");
    timeout_cycle(7, 0, "R4 latency tap7");
    timeout_cycle(6, 1, "R5 latency tap6");
    timeout_cycle(5, 0, "R5 latency tap5");
    timeout_cycle(0, 1, "R5 latency tap0");

    // R6: real acknowledge first
    @(negedge clk);
    tap_sel = 3'd7; mode_berr = 1; as_n = 0;
    repeat (20) @(negedge clk);
    ack_n = 0;
    begin
      bit seen = 0;
      repeat (500) begin
        @(negedge clk);
        if (fake_ack || bus_err) seen = 1;
      end
      check(!seen, "R6 no termination after ack", seen, 0);
    end
    as_n = 1; ack_n = 1;
    repeat (6) @(negedge clk);

    // R8: full timeout after acked and timed-out cycles
    timeout_cycle(7, 0, "R8 fresh count after ack");
    timeout_cycle(7, 1, "R8 fresh count after timeout");

    // R2: brief strobe that is released before timeout leaves no trace
    @(negedge clk); as_n = 0;
    repeat (100) @(negedge clk);
    as_n = 1;
    repeat (300) @(negedge clk);
    check(!fake_ack && !bus_err, "R2 short cycle then idle", {fake_ack, bus_err}, 0);
    timeout_cycle(7, 1, "R8 fresh count after short cycle");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule